// File: doc/BRIEF.md
# Operand Addressing-Mode Unit

This unit produces the source operand for a register-memory ALU instruction. The decoder hands it four things: a three-bit mode code, a register index and a 16-bit constant field, plus a one-cycle start strobe. The constant field serves as an immediate value, an absolute address or a displacement, depending on the mode.

The general-purpose register file sits outside the block. The unit reads it through a combinational read port and writes it through a one-entry write strobe. Memory reads use a request/valid handshake. The unit holds the address steady until the memory answers.

Each operation ends with a one-cycle done pulse, with the operand on its own output. The two auto-modifying modes update their base register at different times. Post-increment writes the register after the access. Pre-decrement writes it before the access, and that access uses the decremented value.

Top module: `operand_resolver`

## Requirements
- R1: Mode code 0 (immediate) returns the constant field as the operand, with done high in the cycle after start and no memory request.
- R2: Mode code 1 (register) returns the contents of the indexed register, with done in the cycle after start and no memory request.
- R3: Mode code 2 (absolute) requests memory at the address given by the constant field and returns the word read.
- R4: Mode code 3 (indirect) requests memory at the address held in the indexed register.
- R5: Mode code 4 (indexed) requests memory at the indexed register plus the constant field, modulo 2^16.
- R6: Mode code 5 (post-increment) reads at the register's old value. It then writes the old value plus one back to that register. The write strobe is high in the same cycle as done.
- R7: Mode code 6 (pre-decrement) writes the register minus one (modulo 2^16) in the cycle after start. It reads memory at that decremented value.
- R8: A memory request holds its address until mem_valid is sampled high. Done follows in the next cycle with the returned data as the operand, and the request is then dropped.
- R9: A start that arrives while a memory access is pending is ignored. It produces no extra done and changes no register.
- R10: After reset, done, mem_req and rf_we are all low.
- R11: Mode code 7 is reserved and behaves exactly like mode code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving an operand (one-cycle strobe) |
| mode | input | 3 | Addressing-mode code |
| reg_idx | input | 2 | Base or source register index |
| disp | input | 16 | Immediate, absolute address or displacement |
| rf_raddr | output | 2 | Register file read index |
| rf_rdata | input | 16 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 2 | Register file write index |
| rf_wdata | output | 16 | Register file write data |
| mem_req | output | 1 | Memory read request, held until valid |
| mem_addr | output | 16 | Memory read address |
| mem_valid | input | 1 | Memory read data valid |
| mem_rdata | input | 16 | Memory read data |
| done | output | 1 | One-cycle completion pulse |
| operand | output | 16 | Resolved operand value |

## Verification
A wrong latched address shows on mem_addr in the first cycle after start, and the responder's data then makes the operand visibly wrong one cycle after valid. A misplaced side effect shows as a write strobe in the wrong cycle or a wrong base register value. Both are visible at the latest one edge after done. A sequencer stuck busy or wrongly idle shows as a latency mismatch against the mode's expected count, or as an extra done pulse after a start that should have been ignored.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    localparam int WORD_W   = 16;
    localparam int REG_CNT  = 4;
    localparam int STEP_VAL = 1;

    typedef enum logic [2:0] {
        AM_IMM  = 3'd0,
        AM_REG  = 3'd1,
        AM_ABS  = 3'd2,
        AM_IND  = 3'd3,
        AM_IDX  = 3'd4,
        AM_POST = 3'd5,
        AM_PRE  = 3'd6,
        AM_RSV  = 3'd7
    } amode_e;

    typedef struct packed {
        logic touches_mem;
        logic wb_early;
        logic wb_late;
        logic from_reg;
    } access_flags_t;

    function automatic access_flags_t decode_mode(amode_e m);
        access_flags_t f;
        f = '0;
        case (m)
            AM_REG:  f.from_reg    = 1'b1;
            AM_ABS,
            AM_IND,
            AM_IDX:  f.touches_mem = 1'b1;
            AM_POST: begin f.touches_mem = 1'b1; f.wb_late  = 1'b1; end
            AM_PRE:  begin f.touches_mem = 1'b1; f.wb_early = 1'b1; end
            default: f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/opaddr_calc.sv
module opaddr_calc
    import opaddr_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int STEP   = STEP_VAL
) (
    input  amode_e              mode,
    input  logic [DATA_W-1:0]   base,
    input  logic [DATA_W-1:0]   disp,
    output access_flags_t       flags,
    output logic [DATA_W-1:0]   addr,
    output logic [DATA_W-1:0]   wb_val,
    output logic [DATA_W-1:0]   direct_val
);
    localparam logic [DATA_W-1:0] STEP_W = DATA_W'(STEP);

    always_comb begin
        flags      = decode_mode(mode);
        addr       = disp;
        wb_val     = base;
        direct_val = flags.from_reg ? base : disp;
        case (mode)
            AM_IND:  addr = base;
            AM_IDX:  addr = base + disp;
            AM_POST: begin
                addr   = base;
                wb_val = base + STEP_W;
            end
            AM_PRE: begin
                wb_val = base - STEP_W;
                addr   = base - STEP_W;
            end
            default: addr = disp;
        endcase
    end

    always_comb begin
        if (flags.wb_early) begin
            p_pre_addr_matches_r7: assert (addr == wb_val);
        end
    end
endmodule

// File: rtl/opaddr_seq.sv
module opaddr_seq (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic is_mem,
    input  logic mem_valid,
    output logic accept,
    output logic complete,
    output logic busy
);
    typedef enum logic {S_IDLE, S_WAIT} seq_state_e;
    seq_state_e state_q;

    assign busy     = (state_q == S_WAIT);
    assign accept   = (state_q == S_IDLE) && start;
    assign complete = busy && mem_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            case (state_q)
                S_IDLE: if (accept && is_mem) state_q <= S_WAIT;
                S_WAIT: if (mem_valid)        state_q <= S_IDLE;
                default:                      state_q <= S_IDLE;
            endcase
        end
    end

    p_idle_after_valid_r8: assert property (@(posedge clk) disable iff (rst)
        complete |=> !busy);
    p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (rst)
        busy && start && !mem_valid |=> busy);
endmodule

// File: rtl/operand_resolver.sv
module operand_resolver
    import opaddr_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int NREG   = REG_CNT,
    parameter int STEP   = STEP_VAL,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] disp,
    output logic [IDX_W-1:0]  rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [DATA_W-1:0] operand
);
    amode_e              mode_in;
    access_flags_t       flags;
    logic [DATA_W-1:0]   calc_addr, calc_wb, calc_direct;
    logic                accept, complete, busy;

    logic                done_q, we_q, pend_q;
    logic [DATA_W-1:0]   addr_q, operand_q, wdata_q, pend_val_q;
    logic [IDX_W-1:0]    waddr_q;

    assign mode_in  = amode_e'(mode);
    assign rf_raddr = reg_idx;

    opaddr_calc #(.DATA_W(DATA_W), .STEP(STEP)) u_calc (
        .mode       (mode_in),
        .base       (rf_rdata),
        .disp       (disp),
        .flags      (flags),
        .addr       (calc_addr),
        .wb_val     (calc_wb),
        .direct_val (calc_direct)
    );

    opaddr_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .is_mem    (flags.touches_mem),
        .mem_valid (mem_valid),
        .accept    (accept),
        .complete  (complete),
        .busy      (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q     <= 1'b0;
            we_q       <= 1'b0;
            pend_q     <= 1'b0;
            addr_q     <= '0;
            operand_q  <= '0;
            wdata_q    <= '0;
            pend_val_q <= '0;
            waddr_q    <= '0;
        end else begin
            done_q <= 1'b0;
            we_q   <= 1'b0;
            if (accept) begin
                waddr_q <= reg_idx;
                if (!flags.touches_mem) begin
                    done_q    <= 1'b1;
                    operand_q <= calc_direct;
                end else begin
                    addr_q     <= calc_addr;
                    we_q       <= flags.wb_early;
                    wdata_q    <= calc_wb;
                    pend_q     <= flags.wb_late;
                    pend_val_q <= calc_wb;
                end
            end else if (complete) begin
                done_q    <= 1'b1;
                operand_q <= mem_rdata;
                if (pend_q) begin
                    we_q    <= 1'b1;
                    wdata_q <= pend_val_q;
                    pend_q  <= 1'b0;
                end
            end
        end
    end

    assign mem_req  = busy;
    assign mem_addr = addr_q;
    assign done     = done_q;
    assign operand  = operand_q;
    assign rf_we    = we_q;
    assign rf_waddr = waddr_q;
    assign rf_wdata = wdata_q;

    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr));
    p_done_after_valid_r8: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_valid |=> done && !mem_req && operand == $past(mem_rdata));
    p_quick_done_r1: assert property (@(posedge clk) disable iff (rst)
        start && !mem_req && (mode == 3'd0 || mode == 3'd1 || mode == 3'd7)
        |=> done && !mem_req && !rf_we);
    p_predec_first_r7: assert property (@(posedge clk) disable iff (rst)
        start && !mem_req && mode == 3'd6 |=> rf_we && mem_req && rf_wdata == mem_addr);
    p_postinc_late_r6: assert property (@(posedge clk) disable iff (rst)
        start && !mem_req && mode == 3'd5 |=> mem_req && !rf_we);
    p_write_timing_r6: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> done || mem_req);
endmodule

// File: tb/sim_operand_resolver.sv
`timescale 1ns/1ps
module sim_operand_resolver;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  reg_idx = '0;
    logic [15:0] disp = '0;
    logic [1:0]  rf_raddr, rf_waddr;
    logic [15:0] rf_rdata, rf_wdata, mem_addr, operand;
    logic        rf_we, mem_req, done;
    logic        mem_valid = 1'b0;
    logic [15:0] mem_rdata = '0;

    logic [15:0] rf [4];
    int          lat_cfg = 0;
    int          wcnt = 0;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    operand_resolver u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .reg_idx(reg_idx),
        .disp(disp), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .done(done), .operand(operand)
    );

    function automatic logic [15:0] memf(logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    assign rf_rdata = rf[rf_raddr];
    always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

    always @(negedge clk) begin
        if (mem_req) begin
            if (wcnt >= lat_cfg) begin
                mem_valid = 1'b1;
                mem_rdata = memf(mem_addr);
            end else begin
                mem_valid = 1'b0;
                wcnt++;
            end
        end else begin
            mem_valid = 1'b0;
            wcnt = 0;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [2:0]  m;
        logic [1:0]  idx;
        logic [15:0] d;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 16'h1234, 4'd0},
        '{3'd1, 2'd1, 16'hDEAD, 4'd0},
        '{3'd2, 2'd0, 16'h0400, 4'd0},
        '{3'd2, 2'd2, 16'hBEEF, 4'd2},
        '{3'd3, 2'd0, 16'h0000, 4'd1},
        '{3'd4, 2'd2, 16'h0020, 4'd0},
        '{3'd5, 2'd1, 16'h0000, 4'd0},
        '{3'd5, 2'd1, 16'h0000, 4'd3},
        '{3'd6, 2'd3, 16'h0000, 4'd0},
        '{3'd6, 2'd0, 16'h0000, 4'd2},
        '{3'd7, 2'd2, 16'h0777, 4'd0},
        '{3'd3, 2'd3, 16'h0000, 4'd0}
    };

    function automatic string tag_of(logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic run_op(input vec_t v);
        logic        exp_mem;
        logic [15:0] base, exp_addr, exp_op, exp_reg;
        int          exp_cyc, cyc;
        logic        req_first, we_first;
        logic [15:0] addr_first;
        string       t;
        t        = tag_of(v.m);
        base     = rf[v.idx];
        exp_reg  = base;
        exp_mem  = 1'b1;
        exp_addr = v.d;
        case (v.m)
            3'd0, 3'd7: begin exp_mem = 1'b0; exp_op = v.d; end
            3'd1: begin exp_mem = 1'b0; exp_op = base; end
            3'd2: exp_addr = v.d;
            3'd3: exp_addr = base;
            3'd4: exp_addr = base + v.d;
            3'd5: begin exp_addr = base; exp_reg = base + 16'd1; end
            default: begin exp_reg = base - 16'd1; exp_addr = exp_reg; end
        endcase
        if (exp_mem) exp_op = memf(exp_addr);
        exp_cyc = exp_mem ? int'(v.lat) + 2 : 1;
        lat_cfg = int'(v.lat);

        @(negedge clk);
        start = 1'b1; mode = v.m; reg_idx = v.idx; disp = v.d;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        req_first = mem_req; addr_first = mem_addr; we_first = rf_we;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == exp_cyc, {t, " latency"}, cyc, exp_cyc);
        chk(operand == exp_op, {t, " operand"}, operand, exp_op);
        chk(req_first == exp_mem, {t, " request"}, req_first, exp_mem);
        if (exp_mem) chk(addr_first == exp_addr, {t, " address"}, addr_first, exp_addr);
        if (v.m == 3'd6) chk(we_first == 1'b1, "R7 early write", we_first, 1);
        chk(rf_we == (v.m == 3'd5), {t, " write with done"}, rf_we, (v.m == 3'd5));
        @(posedge clk); #1;
        chk(rf[v.idx] == exp_reg, {t, " register after"}, rf[v.idx], exp_reg);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rf[0] = 16'h1000; rf[1] = 16'h2222; rf[2] = 16'hFFF0; rf[3] = 16'h0000;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!done && !mem_req && !rf_we, "R10 reset outputs", {done, mem_req, rf_we}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !mem_req && !rf_we, "R10 idle after reset", {done, mem_req, rf_we}, 0);

        for (int i = 0; i < NV; i++) run_op(VECS[i]);

        // R6 post-increment wrapping at the top of the address space
        rf[2] = 16'hFFFF;
        run_op('{3'd5, 2'd2, 16'h0000, 4'd1});
        chk(rf[2] == 16'h0000, "R6 wrap", rf[2], 0);

        // R9 start ignored while a memory access is pending
        lat_cfg = 3;
        @(negedge clk);
        start = 1'b1; mode = 3'd5; reg_idx = 2'd1; disp = 16'h0;
        @(negedge clk);
        chk(mem_addr == 16'h2224, "R9 first access address", mem_addr, 16'h2224);
        start = 1'b1; mode = 3'd0; disp = 16'h9999;
        @(negedge clk);
        start = 1'b0;
        chk(!done && mem_req, "R9 stays busy", {done, mem_req}, 2'b01);
        while (!done) @(negedge clk);
        chk(operand == memf(16'h2224), "R9 operand kept", operand, memf(16'h2224));
        @(negedge clk);
        chk(!done && !mem_req, "R9 no extra done", {done, mem_req}, 0);
        chk(rf[1] == 16'h2225, "R9 single increment", rf[1], 16'h2225);

        // R8 request held across a long wait with stable address
        lat_cfg = 5;
        @(negedge clk);
        start = 1'b1; mode = 3'd2; disp = 16'h0ABC;
        @(negedge clk);
        start = 1'b0;
        repeat (4) begin
            chk(mem_req && mem_addr == 16'h0ABC && !done, "R8 hold", mem_addr, 16'h0ABC);
            @(negedge clk);
        end
        while (!done) @(negedge clk);
        chk(operand == memf(16'h0ABC) && !mem_req, "R8 data after valid", operand, memf(16'h0ABC));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule